// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit buses, called A and B, through a transfer path in each direction. Each path owns a storage register, a capture strobe, a drive enable and a source select. The source select picks either the live value of the opposite bus or the value stored earlier. The bidirectional pins are split into an input vector, an output vector and a per-bit drive-enable vector for each bus. The surrounding pad logic merges them, so no tristate cells appear in the RTL.

The top holds `NUM_SECT` (default two) fully independent sections. Each section has its own complete set of strobes, selects and enables.

All logic runs on one system clock. A capture strobe is a level input, and a register loads on the first clock edge where its strobe is seen high after having been low. It samples the bus value on the wire at that edge. If the block is driving that bus, the wire value is the block's own output. Otherwise it is the external input. Capture does not depend on the enables or the selects.

Top module: `xcvr_dual`

## Requirements
- R1: A synchronous active-low reset clears both registers of every section to zero. While reset is low, every bit of `a_oe` and `b_oe` is 0, whatever the enables are.
- R2: On the first clock edge where `a2b_strobe` is high after a clock edge where it was low, the A-to-B register loads the A wire value. Holding the strobe high loads nothing more. The enables and selects do not affect capture.
- R3: On a rising `b2a_strobe` detected in the same way, the B-to-A register loads the B wire value.
- R4: While B is driven, `a2b_stored`=0 puts the live A value on `b_out` and `a2b_stored`=1 puts the A-to-B register on `b_out`.
- R5: While A is driven, `b2a_stored`=0 puts the live B value on `a_out` and `b2a_stored`=1 puts the B-to-A register on `a_out`.
- R6: `b_drive_en`=1 (active high) drives bus B, and `a_drive_en_n`=0 (active low) drives bus A. A driven bus has all 8 bits of its `*_oe` slice at 1. An undriven bus has its `*_oe` and `*_out` slices at 0.
- R7: With `b_drive_en`=0 and `a_drive_en_n`=1, both buses are isolated: no output enable and no conflict is raised, and both registers still capture.
- R8: With both buses driven and both selects at 1, `b_out` shows the A-to-B register and `a_out` shows the B-to-A register in the same cycle.
- R9: When B carries live A data (A undriven) and both strobes rise together, both registers end up holding the A input. In the mirror case, with A carrying live B data, both end up holding the B input.
- R10: When both stored values cross and both strobes rise in the same edge, each register takes the other's value from before that edge, so the two values swap.
- R11: A register whose source bus is driven by the block captures the block's own driven value, not the external input.
- R12: The live value sent to the other side is the wire value. When both directions select live data, each output forwards the opposite external input.
- R13: `conflict` of a section is 1 in any cycle where the block drives a bus whose `*_ext_drv` input is also 1. Otherwise it is 0.
- R14: Sections are independent: strobes and data on one section change no output of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | NUM_SECT*W | External value of bus A, section s at bits [s*W +: W] |
| b_in | input | NUM_SECT*W | External value of bus B |
| a_ext_drv | input | NUM_SECT | Another agent is driving bus A |
| b_ext_drv | input | NUM_SECT | Another agent is driving bus B |
| a2b_strobe | input | NUM_SECT | Capture strobe of the A-to-B register |
| b2a_strobe | input | NUM_SECT | Capture strobe of the B-to-A register |
| a2b_stored | input | NUM_SECT | 1: B side sends the stored value; 0: live A |
| b2a_stored | input | NUM_SECT | 1: A side sends the stored value; 0: live B |
| b_drive_en | input | NUM_SECT | Active-high enable for driving bus B |
| a_drive_en_n | input | NUM_SECT | Active-low enable for driving bus A |
| a_out | output | NUM_SECT*W | Value driven onto bus A |
| a_oe | output | NUM_SECT*W | Per-bit drive enable of bus A |
| b_out | output | NUM_SECT*W | Value driven onto bus B |
| b_oe | output | NUM_SECT*W | Per-bit drive enable of bus B |
| conflict | output | NUM_SECT | Block and an external agent drive the same bus |

## Verification
Capture and drive can fall in the same cycle: a strobe rises on a bus that the block is itself driving. In that cycle the sampled value comes from the block's own output mux rather than from the input pins. The bench provokes this in three ways. It raises both strobes on one edge with live data flowing, it raises both with stored data crossing, and it captures from a bus driven with stored data while the external input holds a different value. Each case is judged afterwards by switching the section to stored output and reading the register contents at the ports, against values worked out from the wire value present before the edge.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_sel_e;

    function automatic logic strobe_rise(input logic cur, input logic prev);
        return cur & ~prev;
    endfunction

endpackage

// File: rtl/xcvr_path.sv
module xcvr_path
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         drive,
    input  src_sel_e     src,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] out
);

    always_comb begin
        out = '0;
        if (drive) begin
            out = (src == SRC_STORED) ? stored : live;
        end
    end

endmodule

// File: rtl/xcvr_section.sv
module xcvr_section
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         a_ext_drv,
    input  logic         b_ext_drv,
    input  logic         a2b_strobe,
    input  logic         b2a_strobe,
    input  logic         a2b_stored,
    input  logic         b2a_stored,
    input  logic         b_drive_en,
    input  logic         a_drive_en_n,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe,
    output logic         conflict
);

    typedef struct packed {
        logic [W-1:0] reg_ab;
        logic [W-1:0] reg_ba;
        logic         ab_prev;
        logic         ba_prev;
    } sect_state_t;

    sect_state_t state_d, state_q;

    logic         drv_a, drv_b;
    logic [W-1:0] a_src, b_src;
    logic [W-1:0] a_wire, b_wire;

    // Drive enables: gated by reset, polarity differs per side.
    assign drv_a = rst_n & ~a_drive_en_n;
    assign drv_b = rst_n & b_drive_en;

    // Value of each bus as seen by the opposite live path. A side that is
    // driven with stored data presents that data; otherwise the pins.
    assign a_src = (drv_a && b2a_stored) ? state_q.reg_ba : a_in;
    assign b_src = (drv_b && a2b_stored) ? state_q.reg_ab : b_in;

    xcvr_path #(.W(W)) u_path_ab (
        .drive  (drv_b),
        .src    (src_sel_e'(a2b_stored)),
        .live   (a_src),
        .stored (state_q.reg_ab),
        .out    (b_out)
    );

    xcvr_path #(.W(W)) u_path_ba (
        .drive  (drv_a),
        .src    (src_sel_e'(b2a_stored)),
        .live   (b_src),
        .stored (state_q.reg_ba),
        .out    (a_out)
    );

    assign a_wire   = drv_a ? a_out : a_in;
    assign b_wire   = drv_b ? b_out : b_in;
    assign a_oe     = {W{drv_a}};
    assign b_oe     = {W{drv_b}};
    assign conflict = (drv_a & a_ext_drv) | (drv_b & b_ext_drv);

    always_comb begin
        state_d         = state_q;
        state_d.ab_prev = a2b_strobe;
        state_d.ba_prev = b2a_strobe;
        if (strobe_rise(a2b_strobe, state_q.ab_prev)) begin
            state_d.reg_ab = a_wire;
        end
        if (strobe_rise(b2a_strobe, state_q.ba_prev)) begin
            state_d.reg_ba = b_wire;
        end
        if (!rst_n) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

endmodule

// File: rtl/xcvr_dual.sv
module xcvr_dual #(
    parameter int NUM_SECT = 2,
    parameter int W        = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SECT*W-1:0] a_in,
    input  logic [NUM_SECT*W-1:0] b_in,
    input  logic [NUM_SECT-1:0]   a_ext_drv,
    input  logic [NUM_SECT-1:0]   b_ext_drv,
    input  logic [NUM_SECT-1:0]   a2b_strobe,
    input  logic [NUM_SECT-1:0]   b2a_strobe,
    input  logic [NUM_SECT-1:0]   a2b_stored,
    input  logic [NUM_SECT-1:0]   b2a_stored,
    input  logic [NUM_SECT-1:0]   b_drive_en,
    input  logic [NUM_SECT-1:0]   a_drive_en_n,
    output logic [NUM_SECT*W-1:0] a_out,
    output logic [NUM_SECT*W-1:0] a_oe,
    output logic [NUM_SECT*W-1:0] b_out,
    output logic [NUM_SECT*W-1:0] b_oe,
    output logic [NUM_SECT-1:0]   conflict
);

    for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
        xcvr_section #(.W(W)) u_sect (
            .clk          (clk),
            .rst_n        (rst_n),
            .a_in         (a_in[s*W +: W]),
            .b_in         (b_in[s*W +: W]),
            .a_ext_drv    (a_ext_drv[s]),
            .b_ext_drv    (b_ext_drv[s]),
            .a2b_strobe   (a2b_strobe[s]),
            .b2a_strobe   (b2a_strobe[s]),
            .a2b_stored   (a2b_stored[s]),
            .b2a_stored   (b2a_stored[s]),
            .b_drive_en   (b_drive_en[s]),
            .a_drive_en_n (a_drive_en_n[s]),
            .a_out        (a_out[s*W +: W]),
            .a_oe         (a_oe[s*W +: W]),
            .b_out        (b_out[s*W +: W]),
            .b_oe         (b_oe[s*W +: W]),
            .conflict     (conflict[s])
        );
    end

endmodule

// File: rtl/xcvr_dual_chk.sv
module xcvr_dual_chk #(
    parameter int NUM_SECT = 2,
    parameter int W        = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_SECT*W-1:0] a_in,
    input logic [NUM_SECT*W-1:0] b_in,
    input logic [NUM_SECT-1:0]   a_ext_drv,
    input logic [NUM_SECT-1:0]   b_ext_drv,
    input logic [NUM_SECT-1:0]   a2b_strobe,
    input logic [NUM_SECT-1:0]   b2a_strobe,
    input logic [NUM_SECT-1:0]   a2b_stored,
    input logic [NUM_SECT-1:0]   b2a_stored,
    input logic [NUM_SECT-1:0]   b_drive_en,
    input logic [NUM_SECT-1:0]   a_drive_en_n,
    input logic [NUM_SECT*W-1:0] a_out,
    input logic [NUM_SECT*W-1:0] a_oe,
    input logic [NUM_SECT*W-1:0] b_out,
    input logic [NUM_SECT*W-1:0] b_oe,
    input logic [NUM_SECT-1:0]   conflict
);

    always_comb begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (a_oe == '0 && b_oe == '0);
        end
    end

    property p_isolated;
        @(posedge clk) disable iff (!rst_n)
        (b_drive_en == '0 && (&a_drive_en_n)) |-> (a_oe == '0 && b_oe == '0 && conflict == '0);
    endproperty
    assert_isolation_R7: assert property (p_isolated);

    for (genvar s = 0; s < NUM_SECT; s++) begin : g_chk
        logic ab_prev, ba_prev;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ab_prev <= 1'b0;
                ba_prev <= 1'b0;
            end else begin
                ab_prev <= a2b_strobe[s];
                ba_prev <= b2a_strobe[s];
            end
        end

        assert_live_ab_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (b_drive_en[s] && !a2b_stored[s] && a_drive_en_n[s])
                |-> b_out[s*W +: W] == a_in[s*W +: W]);

        assert_live_ba_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!a_drive_en_n[s] && !b2a_stored[s] && !b_drive_en[s])
                |-> a_out[s*W +: W] == b_in[s*W +: W]);

        assert_capture_ab_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (a2b_strobe[s] && !ab_prev && a_drive_en_n[s])
                |=> (!(b_drive_en[s] && a2b_stored[s]) || b_out[s*W +: W] == $past(a_in[s*W +: W])));

        assert_capture_ba_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (b2a_strobe[s] && !ba_prev && !b_drive_en[s])
                |=> (a_drive_en_n[s] || !b2a_stored[s] || a_out[s*W +: W] == $past(b_in[s*W +: W])));

        assert_stored_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (b_drive_en[s] && a2b_stored[s] && $past(rst_n)
             && $past(b_drive_en[s] && a2b_stored[s])
             && !$past(a2b_strobe[s] && !ab_prev))
                |-> $stable(b_out[s*W +: W]));

        assert_conflict_cause_R13: assert property (@(posedge clk) disable iff (!rst_n)
            conflict[s] |-> ((a_ext_drv[s] && a_oe[s*W]) || (b_ext_drv[s] && b_oe[s*W])));
    end

endmodule

bind xcvr_dual xcvr_dual_chk #(.NUM_SECT(NUM_SECT), .W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .a_in         (a_in),
    .b_in         (b_in),
    .a_ext_drv    (a_ext_drv),
    .b_ext_drv    (b_ext_drv),
    .a2b_strobe   (a2b_strobe),
    .b2a_strobe   (b2a_strobe),
    .a2b_stored   (a2b_stored),
    .b2a_stored   (b2a_stored),
    .b_drive_en   (b_drive_en),
    .a_drive_en_n (a_drive_en_n),
    .a_out        (a_out),
    .a_oe         (a_oe),
    .b_out        (b_out),
    .b_oe         (b_oe),
    .conflict     (conflict)
);

// File: tb/xcvr_dual_bench.sv
module xcvr_dual_bench;

    localparam int NS = 2;
    localparam int W  = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NS*W-1:0] a_in, b_in;
    logic [NS-1:0] a_ext_drv, b_ext_drv, a2b_strobe, b2a_strobe;
    logic [NS-1:0] a2b_stored, b2a_stored, b_drive_en, a_drive_en_n;
    logic [NS*W-1:0] a_out, a_oe, b_out, b_oe;
    logic [NS-1:0] conflict;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    xcvr_dual #(.NUM_SECT(NS), .W(W)) u_xcvr_dual (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .a_ext_drv(a_ext_drv), .b_ext_drv(b_ext_drv),
        .a2b_strobe(a2b_strobe), .b2a_strobe(b2a_strobe),
        .a2b_stored(a2b_stored), .b2a_stored(b2a_stored),
        .b_drive_en(b_drive_en), .a_drive_en_n(a_drive_en_n),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
        .conflict(conflict)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic ctrl(input int s, input logic bden, input logic a2bs,
                        input logic aden_n, input logic b2as);
        b_drive_en[s]   = bden;
        a2b_stored[s]   = a2bs;
        a_drive_en_n[s] = aden_n;
        b2a_stored[s]   = b2as;
        settle();
    endtask

    task automatic pulse(input int s, input logic ab, input logic ba);
        a2b_strobe[s] = ab;
        b2a_strobe[s] = ba;
        tick();
        a2b_strobe[s] = 1'b0;
        b2a_strobe[s] = 1'b0;
        tick();
    endtask

    function automatic logic [7:0] bo(input int s); return b_out[s*W +: W]; endfunction
    function automatic logic [7:0] ao(input int s); return a_out[s*W +: W]; endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        ctrl(0, 1'b1, 1'b1, 1'b0, 1'b1);
        tick(); tick();
        chk("R1 oe low in reset", {a_oe[7:0], b_oe[7:0]}, 16'h0000);
        ctrl(0, 1'b0, 1'b0, 1'b1, 1'b0);
        rst_n = 1'b1;
        tick();
        ctrl(0, 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R1 stored zero after reset", bo(0), 8'h00);
        chk("R6 b_oe all ones when driven", b_oe[7:0], 8'hFF);
        chk("R6 a idle oe and out", {a_oe[7:0], ao(0)}, 16'h0000);
    endtask

    task automatic t_capture();
        ctrl(0, 1'b0, 1'b0, 1'b1, 1'b0);
        a_in[7:0] = 8'hA5;
        pulse(0, 1'b1, 1'b0);
        chk("R7 isolation no oe", {a_oe[7:0], b_oe[7:0]}, 16'h0000);
        a_in[7:0] = 8'h3C;
        ctrl(0, 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R2 capture in isolation", bo(0), 8'hA5);
        ctrl(0, 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R4 live a to b", bo(0), 8'h3C);
        // held strobe loads only once
        ctrl(0, 1'b0, 1'b0, 1'b1, 1'b0);
        a_in[7:0] = 8'h11;
        a2b_strobe[0] = 1'b1;
        tick();
        a_in[7:0] = 8'h22;
        tick();
        a2b_strobe[0] = 1'b0;
        tick();
        ctrl(0, 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R2 held strobe no reload", bo(0), 8'h11);
    endtask

    task automatic t_ba();
        ctrl(0, 1'b0, 1'b0, 1'b1, 1'b0);
        b_in[7:0] = 8'h5A;
        pulse(0, 1'b0, 1'b1);
        b_in[7:0] = 8'h66;
        ctrl(0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R3 capture b", ao(0), 8'h5A);
        chk("R6 a_oe active-low enable", a_oe[7:0], 8'hFF);
        chk("R6 b idle", {b_oe[7:0], bo(0)}, 16'h0000);
        ctrl(0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R5 live b to a", ao(0), 8'h66);
        ctrl(0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R5 stored b to a", ao(0), 8'h5A);
    endtask

    task automatic t_cross();
        ctrl(0, 1'b1, 1'b1, 1'b0, 1'b1);
        chk("R8 crossing b side", bo(0), 8'h11);
        chk("R8 crossing a side", ao(0), 8'h5A);
        pulse(0, 1'b1, 1'b1);
        chk("R10 swap b side", bo(0), 8'h5A);
        chk("R10 swap a side", ao(0), 8'h11);
    endtask

    task automatic t_live_both();
        ctrl(0, 1'b1, 1'b0, 1'b1, 1'b0);
        a_in[7:0] = 8'hC3;
        pulse(0, 1'b1, 1'b1);
        ctrl(0, 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R9 a value in ab reg", bo(0), 8'hC3);
        ctrl(0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R9 a value in ba reg", ao(0), 8'hC3);
        ctrl(0, 1'b0, 1'b0, 1'b0, 1'b0);
        b_in[7:0] = 8'h96;
        pulse(0, 1'b1, 1'b1);
        ctrl(0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R9 mirror ba reg", ao(0), 8'h96);
        ctrl(0, 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R9 mirror ab reg", bo(0), 8'h96);
    endtask

    task automatic t_own_drive();
        ctrl(0, 1'b0, 1'b0, 1'b1, 1'b0);
        b_in[7:0] = 8'h77;
        pulse(0, 1'b0, 1'b1);
        ctrl(0, 1'b0, 1'b0, 1'b0, 1'b1);
        a_in[7:0] = 8'h01;
        pulse(0, 1'b1, 1'b0);
        ctrl(0, 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R11 captured own driven value", bo(0), 8'h77);
    endtask

    task automatic t_live_src();
        ctrl(0, 1'b0, 1'b0, 1'b1, 1'b0);
        a_in[7:0] = 8'hE1;
        pulse(0, 1'b1, 1'b0);
        a_in[7:0] = 8'h01;
        ctrl(0, 1'b1, 1'b0, 1'b0, 1'b1);
        chk("R12 live carries driven A", bo(0), 8'h77);
        b_in[7:0] = 8'h4B;
        ctrl(0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R12 both live b side", bo(0), 8'h01);
        chk("R12 both live a side", ao(0), 8'h4B);
    endtask

    task automatic t_conflict();
        ctrl(0, 1'b1, 1'b1, 1'b1, 1'b0);
        b_ext_drv[0] = 1'b1; settle();
        chk("R13 conflict on b", {15'd0, conflict[0]}, 16'd1);
        ctrl(0, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R13 no conflict when idle", {15'd0, conflict[0]}, 16'd0);
        b_ext_drv[0] = 1'b0;
        a_ext_drv[0] = 1'b1;
        ctrl(0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R13 conflict on a", {15'd0, conflict[0]}, 16'd1);
        ctrl(0, 1'b0, 1'b0, 1'b1, 1'b1);
        chk("R7 isolated no conflict", {15'd0, conflict[0]}, 16'd0);
        a_ext_drv[0] = 1'b0;
    endtask

    task automatic t_indep();
        ctrl(1, 1'b0, 1'b0, 1'b1, 1'b0);
        a_in[15:8] = 8'hD2;
        pulse(1, 1'b1, 1'b0);
        ctrl(1, 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R14 section1 capture", bo(1), 8'hD2);
        ctrl(0, 1'b0, 1'b0, 1'b1, 1'b0);
        a_in[7:0]  = 8'h00;
        a_in[15:8] = 8'hFF;
        pulse(0, 1'b1, 1'b1);
        chk("R14 section1 untouched", bo(1), 8'hD2);
        ctrl(0, 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R14 section0 captured", bo(0), 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        a_in = '0; b_in = '0;
        a_ext_drv = '0; b_ext_drv = '0;
        a2b_strobe = '0; b2a_strobe = '0;
        a2b_stored = '0; b2a_stored = '0;
        b_drive_en = '0; a_drive_en_n = '1;
        t_reset();
        t_capture();
        t_ba();
        t_cross();
        t_live_both();
        t_own_drive();
        t_live_src();
        t_conflict();
        t_indep();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule